// File: doc/BRIEF.md
# Two-Stage Card Clock Prescaler

This block produces the clock for a smart card from a fast on-chip clock and an optional external auxiliary clock. A first stage divides the system clock by 1, 2, 4, 6, 8, 10 or 12 to give an intermediate clock. A second stage then picks the card clock from one of several sources: the system clock, the intermediate clock, the intermediate clock divided by 2 or 4, the system clock divided by 2 or 4, the auxiliary clock, or the auxiliary clock divided by 2. An 8-bit configuration register with a write port holds both codes. A stop input parks the card clock low without cutting a pulse short.

The whole block runs on one core clock, `clk_i`, at twice the system clock rate. The system clock is therefore one that toggles on every core cycle. Every internal selection reduces to a card clock that toggles every H core cycles, where H is the half-period in core cycles. The card clock output comes straight from a flip-flop. The auxiliary input is synchronised into the core domain before it is used.

Selection changes take effect only at a falling edge of the card clock, or while the clock is stopped. This keeps every high and low phase full length.

Top module: `cardclk_presc`

## Requirements
- R1: After reset the register reads 0x10, with select code 1 and divider code 0. The card clock starts low and the stopped flag is low. The card clock then toggles on every core cycle (H = 1).
- R2: A write places the select code in bits 6:4 and the divider code in bits 2:0. Bits 7 and 3 always read 0. The register changes only on a cycle with `wr_en_i` high.
- R3: A write whose divider field is 7 leaves the divider code unchanged. The select field of the same write is still applied.
- R4: For internal select codes, the high and low phases each last H core cycles, where r = 1 for divider code 0 and r = 2·code otherwise. H is 1 for select 0, r for select 1, 2r for select 2, 4r for select 3, 2 for select 6 and 4 for select 7.
- R5: With select 4, the card clock rises only on a synchronised rising edge of the auxiliary input. It then follows that input's level, so its high and low phases match those of the auxiliary input.
- R6: With select 5, the card clock toggles on each synchronised rising edge of the auxiliary input. This halves its frequency with a 50% duty cycle.
- R7: A new setting loads at the first falling edge of the card clock at or after the write edge. This is at most 2·H(old) core cycles after the write. The first high phase that follows lasts exactly H(new).
- R8: While `stop_i` is high, the card clock finishes its current high phase and then stays low. The stopped flag is high whenever the clock is parked, and the card clock is low whenever the flag is high.
- R9: When `stop_i` is released with an internal selection, the card clock stays low and rises H+1 core cycles after the release is driven.
- R10: A write that moves the select code between the internal group (0, 1, 2, 3, 6, 7) and the auxiliary group (4, 5) is ignored for the select field unless the stopped flag is high. The divider field of that write is still applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock, twice the system clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| stop_i | input | 1 | Request to park the card clock low |
| aux_clk_i | input | 1 | Auxiliary external clock, asynchronous |
| card_clk_o | output | 1 | Card clock |
| clk_stopped_o | output | 1 | Card clock is parked low |
| cfg_o | output | 8 | Register readback |

## Verification
The assertions assume that `stop_i`, `wr_en_i` and `wr_data_i` are synchronous to `clk_i` and hold known values once reset is released. They also assume that each phase of the auxiliary input lasts several core cycles, so the synchroniser sees every edge. The stimulus keeps within these limits: it changes every input a quarter period after a rising edge, and it toggles the auxiliary clock every seven core cycles. Crossings between source groups are attempted both while running and after the stopped flag has been seen high.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam int REG_W     = 8;
    localparam int SEL_W     = 3;
    localparam int DIV_W     = 3;
    localparam int SEL_LSB   = 4;
    localparam int DIV_LSB   = 0;
    localparam int MAX_RATIO = 2 * ((1 << DIV_W) - 2);
    localparam int MAX_HALF  = 4 * MAX_RATIO;
    localparam int CNT_W     = $clog2(MAX_HALF + 1);

    localparam logic [DIV_W-1:0] DIV_RSVD = '1;

    typedef enum logic [SEL_W-1:0] {
        SEL_SYS  = 3'd0,
        SEL_MID  = 3'd1,
        SEL_MID2 = 3'd2,
        SEL_MID4 = 3'd3,
        SEL_AUX  = 3'd4,
        SEL_AUX2 = 3'd5,
        SEL_SYS2 = 3'd6,
        SEL_SYS4 = 3'd7
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{sel: SEL_MID, div: '0};

    function automatic logic is_aux(sel_e s);
        return (s == SEL_AUX) || (s == SEL_AUX2);
    endfunction

    // Half-period of the card clock in core cycles for an internal source.
    function automatic logic [CNT_W-1:0] half_period(sel_e s, logic [DIV_W-1:0] d);
        logic [CNT_W-1:0] r;
        r = (d == '0) ? CNT_W'(1) : CNT_W'({d, 1'b0});
        unique case (s)
            SEL_SYS:  return CNT_W'(1);
            SEL_MID:  return r;
            SEL_MID2: return r << 1;
            SEL_MID4: return r << 2;
            SEL_SYS2: return CNT_W'(2);
            SEL_SYS4: return CNT_W'(4);
            default:  return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/ccp_cfg_reg.sv
module ccp_cfg_reg
    import ccp_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             stopped_i,
    output cfg_t             cfg_q_o,
    output cfg_t             cfg_d_o
);

    cfg_t             cfg_d, cfg_q;
    sel_e             wsel;
    logic [DIV_W-1:0] wdiv;
    logic             unused_wr_bits;

    assign unused_wr_bits = wr_data_i[REG_W-1] ^ wr_data_i[SEL_LSB-1];

    always_comb begin
        cfg_d = cfg_q;
        wsel  = sel_e'(wr_data_i[SEL_LSB +: SEL_W]);
        wdiv  = wr_data_i[DIV_LSB +: DIV_W];
        if (wr_en_i) begin
            if (wdiv != DIV_RSVD) begin
                cfg_d.div = wdiv;
            end
            if (stopped_i || (is_aux(wsel) == is_aux(cfg_q.sel))) begin
                cfg_d.sel = wsel;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_q_o = cfg_q;
    assign cfg_d_o = cfg_d;

endmodule

// File: rtl/ccp_aux_sync.sv
module ccp_aux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic aux_i,
    output logic level_o,
    output logic rise_o
);

    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], aux_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/ccp_clk_gen.sv
module ccp_clk_gen
    import ccp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_i,
    input  cfg_t cfg_next_i,
    input  logic aux_level_i,
    input  logic aux_rise_i,
    output logic clk_o,
    output logic stopped_o
);

    typedef struct packed {
        cfg_t             act;
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             halted;
    } gen_t;

    gen_t             st_d, st_q;
    logic [CNT_W-1:0] half;
    logic             load;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        half = half_period(st_q.act.sel, st_q.act.div);
        if (!is_aux(st_q.act.sel)) begin
            if (st_q.halted) begin
                st_d.out    = 1'b0;
                st_d.cnt    = '0;
                st_d.halted = stop_i;
                load        = 1'b1;
            end else if (st_q.cnt == half - CNT_W'(1)) begin
                st_d.cnt = '0;
                if (st_q.out) begin
                    st_d.out    = 1'b0;
                    st_d.halted = stop_i;
                    load        = 1'b1;
                end else if (stop_i) begin
                    st_d.halted = 1'b1;
                    load        = 1'b1;
                end else begin
                    st_d.out = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            st_d.cnt = '0;
            if (st_q.act.sel == SEL_AUX) begin
                st_d.out = st_q.out ? aux_level_i : (aux_rise_i & ~stop_i);
            end else if (aux_rise_i) begin
                st_d.out = st_q.out ? 1'b0 : ~stop_i;
            end
            st_d.halted = stop_i & ~st_d.out;
            load        = st_q.halted | (st_q.out & ~st_d.out);
        end
        if (load) begin
            st_d.act = cfg_next_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{act: CFG_RESET, cnt: '0, out: 1'b0, halted: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o     = st_q.out;
    assign stopped_o = st_q.halted;

endmodule

// File: rtl/cardclk_presc.sv
module cardclk_presc
    import ccp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             stop_i,
    input  logic             aux_clk_i,
    output logic             card_clk_o,
    output logic             clk_stopped_o,
    output logic [REG_W-1:0] cfg_o
);

    cfg_t cfg_q, cfg_d;
    logic aux_level, aux_rise;
    logic stopped;

    ccp_cfg_reg u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .stopped_i (stopped),
        .cfg_q_o   (cfg_q),
        .cfg_d_o   (cfg_d)
    );

    ccp_aux_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .aux_i   (aux_clk_i),
        .level_o (aux_level),
        .rise_o  (aux_rise)
    );

    ccp_clk_gen u_gen (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .stop_i      (stop_i),
        .cfg_next_i  (cfg_d),
        .aux_level_i (aux_level),
        .aux_rise_i  (aux_rise),
        .clk_o       (card_clk_o),
        .stopped_o   (stopped)
    );

    assign clk_stopped_o = stopped;

    always_comb begin
        cfg_o = '0;
        cfg_o[SEL_LSB +: SEL_W] = cfg_q.sel;
        cfg_o[DIV_LSB +: DIV_W] = cfg_q.div;
    end

endmodule

// File: rtl/cardclk_presc_chk.sv
module cardclk_presc_chk
    import ccp_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic             stop_i,
    input logic             card_clk_o,
    input logic             clk_stopped_o,
    input logic [REG_W-1:0] cfg_o
);

    logic aux_grp;
    assign aux_grp = cfg_o[SEL_LSB+2] & ~cfg_o[SEL_LSB+1];

    AST_DIV_NOT_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_o[DIV_LSB +: DIV_W] != DIV_RSVD); // R3

    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(cfg_o)); // R2

    AST_STOPPED_IS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_stopped_o |-> !card_clk_o); // R8

    AST_STOP_BLOCKS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !card_clk_o) |=> !card_clk_o); // R8

    AST_NO_CROSS_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clk_stopped_o |=> (aux_grp == $past(aux_grp))); // R10

endmodule

bind cardclk_presc cardclk_presc_chk u_chk (.*);

// File: tb/cardclk_presc_test.sv
module cardclk_presc_test;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int AUX_HALF   = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stop = 1'b0;
    logic       aux = 1'b0;
    logic       card_clk, stopped;
    logic [7:0] cfg;

    int n_checks = 0;
    int n_fail   = 0;

    cardclk_presc uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .stop_i        (stop),
        .aux_clk_i     (aux),
        .card_clk_o    (card_clk),
        .clk_stopped_o (stopped),
        .cfg_o         (cfg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int halfp(int s, int d);
        int r;
        r = (d == 0) ? 1 : 2 * d;
        case (s)
            0: return 1;
            1: return r;
            2: return 2 * r;
            3: return 4 * r;
            6: return 2;
            7: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic bit isaux(int s);
        return (s == 4) || (s == 5);
    endfunction

    // Behavioural reference model, stepped on every rising edge
    int m_sel, m_div, a_sel, a_div, m_cnt;
    bit m_out, m_halt, sq0, sq1, sq2;

    task automatic model_step();
        int n_sel, n_div, ws, wd, h, nc;
        bit lvl, rise, no, nh, ld;
        if (!rst_n) begin
            m_sel = 1; m_div = 0; a_sel = 1; a_div = 0; m_cnt = 0;
            m_out = 0; m_halt = 0; sq0 = 0; sq1 = 0; sq2 = 0;
            return;
        end
        n_sel = m_sel; n_div = m_div;
        if (wr_en) begin
            ws = int'(wr_data[6:4]);
            wd = int'(wr_data[2:0]);
            if (wd != 7) n_div = wd;
            if (m_halt || (isaux(ws) == isaux(m_sel))) n_sel = ws;
        end
        lvl = sq1; rise = sq1 && !sq2;
        no = m_out; nh = m_halt; nc = m_cnt; ld = 0;
        if (!isaux(a_sel)) begin
            h = halfp(a_sel, a_div);
            if (m_halt) begin
                no = 0; nc = 0; nh = stop; ld = 1;
            end else if (m_cnt == h - 1) begin
                nc = 0;
                if (m_out) begin no = 0; nh = stop; ld = 1; end
                else if (stop) begin nh = 1; ld = 1; end
                else no = 1;
            end else begin
                nc = m_cnt + 1;
            end
        end else begin
            nc = 0;
            if (a_sel == 4) no = m_out ? lvl : (rise && !stop);
            else if (rise) no = m_out ? 1'b0 : !stop;
            nh = stop && !no;
            ld = m_halt || (m_out && !no);
        end
        if (ld) begin a_sel = n_sel; a_div = n_div; end
        m_out = no; m_halt = nh; m_cnt = nc; m_sel = n_sel; m_div = n_div;
        sq2 = sq1; sq1 = sq0; sq0 = aux;
    endtask

    always @(posedge clk) begin
        model_step();
        #(QTR);
        if (rst_n) begin
            chk(card_clk === m_out, "R4/R7 card clock vs model", int'(card_clk), int'(m_out));
            chk(stopped === m_halt, "R8 stopped flag vs model", int'(stopped), int'(m_halt));
            chk(cfg === {1'b0, 3'(m_sel), 1'b0, 3'(m_div)}, "R2 readback vs model",
                int'(cfg), (m_sel << 4) | m_div);
        end
    end

    task automatic tick();
        @(posedge clk);
        #(QTR);
    endtask

    task automatic wr(input int s, input int d);
        wr_en   = 1'b1;
        wr_data = 8'((s << 4) | d);
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic wait_falls(input int n);
        for (int i = 0; i < n; i++) begin
            while (!card_clk) tick();
            while (card_clk) tick();
        end
    endtask

    task automatic measure(input int h, input string req);
        int hi, lo;
        while (card_clk) tick();
        while (!card_clk) tick();
        hi = 0; lo = 0;
        while (card_clk) begin hi++; tick(); end
        while (!card_clk) begin lo++; tick(); end
        chk(hi == h, req, hi, h);
        chk(hi + lo == 2 * h, req, hi + lo, 2 * h);
    endtask

    initial begin
        forever begin
            repeat (AUX_HALF) tick();
            aux = ~aux;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sels[6] = '{0, 1, 2, 3, 6, 7};
        int cur_s, cur_d, ns, nd, t, hi, cnt;
        bit prev;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk(cfg == 8'h10, "R1 reset readback", int'(cfg), 16);
        chk(card_clk == 1'b0, "R1 reset card clock", int'(card_clk), 0);
        chk(stopped == 1'b0, "R1 reset stopped", int'(stopped), 0);
        measure(1, "R1 default half-period");

        // R2 field layout, bits 7 and 3 read zero
        wr_en = 1'b1; wr_data = 8'hBA; tick(); wr_en = 1'b0;
        chk(cfg == 8'h32, "R2 layout readback", int'(cfg), 8'h32);
        // R3 reserved divider code ignored, select still taken
        wr(6, 7);
        chk(cfg == 8'h62, "R3 reserved divider", int'(cfg), 8'h62);

        // R4 every internal combination
        for (int d = 0; d < 7; d++) begin
            for (int k = 0; k < 6; k++) begin
                wr(sels[k], d);
                wait_falls(2);
                measure(halfp(sels[k], d), "R4 period/high time");
            end
        end

        // R10 crossing while running is refused, divider still taken
        wr(1, 0);
        wait_falls(2);
        wr(4, 3);
        chk(cfg == 8'h13, "R10 cross refused while running", int'(cfg), 8'h13);

        // R8 stop in mid high phase, R9 release
        wr(3, 1);
        wait_falls(2);
        while (card_clk) tick();
        while (!card_clk) tick();
        hi = 0;
        stop = 1'b1;
        while (card_clk) begin hi++; tick(); end
        chk(hi == 8, "R8 high phase completes", hi, 8);
        chk(stopped == 1'b1, "R8 stopped flag at fall", int'(stopped), 1);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (card_clk) cnt++;
            tick();
        end
        chk(cnt == 0, "R8 held low while stopped", cnt, 0);
        stop = 1'b0;
        t = 0;
        while (!card_clk) begin t++; tick(); end
        chk(t == 9, "R9 restart latency", t, 9);

        // R10 crossing accepted when stopped; R5 / R6 auxiliary modes
        stop = 1'b1;
        while (!stopped) tick();
        wr(4, 0);
        chk(cfg == 8'h40, "R10 cross accepted when stopped", int'(cfg), 8'h40);
        stop = 1'b0;
        measure(AUX_HALF, "R5 aux follow");
        measure(AUX_HALF, "R5 aux follow again");
        wr(5, 0);
        wait_falls(2);
        measure(2 * AUX_HALF, "R6 aux half rate");
        wr(2, 0);
        chk(cfg == 8'h50, "R10 aux to internal refused", int'(cfg), 8'h50);
        stop = 1'b1;
        while (!stopped) tick();
        wr(1, 0);
        stop = 1'b0;
        chk(cfg == 8'h10, "R10 back to internal", int'(cfg), 8'h10);
        wait_falls(2);

        // R7 changes at random phases: latency bound and first pulse width
        cur_s = 1; cur_d = 0;
        for (int i = 0; i < 30; i++) begin
            repeat ($urandom_range(0, 40)) tick();
            ns = sels[$urandom_range(0, 5)];
            nd = $urandom_range(0, 6);
            prev = card_clk;
            wr(ns, nd);
            t = 1;
            while (!(prev && !card_clk)) begin
                prev = card_clk;
                tick();
                t++;
            end
            chk(t <= 2 * halfp(cur_s, cur_d), "R7 switch latency", t, 2 * halfp(cur_s, cur_d));
            while (!card_clk) tick();
            hi = 0;
            while (card_clk) begin hi++; tick(); end
            chk(hi == halfp(ns, nd), "R7 first pulse full width", hi, halfp(ns, nd));
            cur_s = ns; cur_d = nd;
        end

        repeat (5) tick();
        finish_run();
    end

endmodule